// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Core

This block is a small programmable logic array in which only the AND side can be programmed. Four external inputs and four section outputs feed a shared plane of literals. Every section owns three product terms of its own, and a fixed OR gate combines them. Because section outputs return to the literal plane, a function that needs more than three terms can be split across two sections, with one section feeding the next. Each section output then passes through a programmable inverter and an output enable before it reaches its pin.

The fuse map arrives as a serial bit stream into a shift chain. A commit strobe copies the whole chain into the active map in one step, so the logic never shows a partly loaded map. The logic path from `dataIn` to `pinOut` is purely combinational. Section feedback is settled inside the block for any map whose section-to-section connections form no loop.

Top module: `pal_core`

## Requirements
- R1: While `rstN` is low, and after reset until a map is committed, every pin of `pinOut` is high impedance and the shift chain and active map are all zero. A commit of the cleared chain leaves every pin high impedance.
- R2: While `cfgShift` is high, each rising clock edge shifts `cfgData` into the top of the 200-bit chain and moves the chain down by one bit. Bit 0 of the map is shifted first. Section s uses bits s*50 .. s*50+49: term t holds fuse columns at s*50+t*16+c, the inversion bit is at s*50+48, and the enable bit is at s*50+49.
- R3: At the first rising edge where `cfgCommit` is high after being low, the chain contents become the active map. Holding `cfgCommit` high does not commit again. Shifting without a commit leaves `pinOut` unchanged.
- R4: Literal column 2k is the true form and column 2k+1 is the complement of signal k. Signals 0..3 are `dataIn[0..3]`, and signal 4+s is the feedback of section s.
- R5: A product term is the AND of its connected literals. A term with no connected literal is 0. A term that connects both forms of the same signal is 0.
- R6: A section output is the OR of its own three terms only. A term programmed in one section has no effect on any other section.
- R7: Feedback settles through chains of up to four sections in either section order, provided the map is acyclic.
- R8: When the inversion bit is set, the pin shows the complement of the section's OR sum. The feedback value is always the uninverted OR sum.
- R9: When the enable bit is clear, the section's pin is high impedance and its feedback still drives other sections.
- R10: `pinOut` follows changes on `dataIn` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgData | input | 1 | Serial fuse-map bit |
| cfgShift | input | 1 | Shift enable for the fuse chain |
| cfgCommit | input | 1 | Commit request, acted on at its rising level |
| dataIn | input | 4 | Logic inputs |
| pinOut | output | 4 | Section outputs, high impedance when disabled |

## Verification
The bench uses the default build: four inputs, four sections and three terms per section. That gives 16 literal columns and a 200-bit chain, so one full load takes 200 shift cycles and the bench can reload the map many times. With this build a four-section feedback chain can be tested in both section orders, which uses every settling pass the plane provides. A section can also be left disabled while its feedback still drives another section.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Strobes passed from configuration control to the fuse datapath
  typedef struct packed {
    logic shift;
    logic commit;
  } cfgStrobe_t;

endpackage

// File: rtl/pal_cfg_ctrl.sv
module pal_cfg_ctrl
  import pal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgShift,
  input  logic       cfgCommit,
  output cfgStrobe_t strobe
);

  logic commitPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) commitPrev <= 1'b0;
    else       commitPrev <= cfgCommit;
  end

  always_comb begin
    strobe.shift  = cfgShift;
    strobe.commit = cfgCommit & ~commitPrev;
  end

  // R3: a held commit request yields one strobe only
  p_single_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !strobe.commit);

endmodule

// File: rtl/pal_fuse_store.sv
module pal_fuse_store
  import pal_pkg::*;
#(
  parameter int TOTAL_BITS = 200
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgData,
  input  cfgStrobe_t            strobe,
  output logic [TOTAL_BITS-1:0] activeMap
);

  logic [TOTAL_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      activeMap <= '0;
    end else begin
      if (strobe.shift)  shiftReg  <= {cfgData, shiftReg[TOTAL_BITS-1:1]};
      if (strobe.commit) activeMap <= shiftReg;
    end
  end

  // R2: new bit enters at the top of the chain
  p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> shiftReg[TOTAL_BITS-1] == $past(cfgData));

  // R3: commit copies the chain as it stood before the edge
  p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> activeMap == $past(shiftReg));

  // R3: no commit, no change in the active map
  p_map_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(activeMap));

endmodule

// File: rtl/pal_and_or_plane.sv
module pal_and_or_plane #(
  parameter int NUM_IN  = 4,
  parameter int NUM_SEC = 4,
  parameter int TERMS   = 3,
  localparam int SIGS     = NUM_IN + NUM_SEC,
  localparam int LIT      = 2 * SIGS,
  localparam int SEC_TERM = TERMS * LIT
) (
  input  logic [NUM_SEC*SEC_TERM-1:0] termFuse,
  input  logic [NUM_IN-1:0]           dataIn,
  output logic [NUM_SEC-1:0]          orSum
);

  function automatic logic sectionSum(input logic [SEC_TERM-1:0] f,
                                      input logic [SIGS-1:0]     sig);
    logic [LIT-1:0] lit;
    logic [LIT-1:0] tf;
    logic           acc;
    for (int k = 0; k < SIGS; k++) begin
      lit[2*k]   = sig[k];
      lit[2*k+1] = ~sig[k];
    end
    acc = 1'b0;
    for (int t = 0; t < TERMS; t++) begin
      tf  = f[t*LIT +: LIT];
      acc = acc | ((|tf) & (&(lit | ~tf)));
    end
    return acc;
  endfunction

  // Feedback relaxed over NUM_SEC passes: any acyclic chain settles
  always_comb begin
    logic [NUM_SEC-1:0] fb;
    logic [NUM_SEC-1:0] nxt;
    fb  = '0;
    nxt = '0;
    for (int p = 0; p < NUM_SEC; p++) begin
      for (int s = 0; s < NUM_SEC; s++)
        nxt[s] = sectionSum(termFuse[s*SEC_TERM +: SEC_TERM], {fb, dataIn});
      fb = nxt;
    end
    orSum = fb;
  end

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_chk
    // R5: a section with no connected literal anywhere stays at 0
    always_comb begin
      if (termFuse[s*SEC_TERM +: SEC_TERM] == '0)
        p_empty_section_r5: assert (orSum[s] == 1'b0);
    end
  end

endmodule

// File: rtl/pal_core.sv
module pal_core
  import pal_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_SEC = 4,
  parameter int TERMS   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgData,
  input  logic               cfgShift,
  input  logic               cfgCommit,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_SEC-1:0] pinOut
);

  localparam int LIT        = 2 * (NUM_IN + NUM_SEC);
  localparam int SEC_TERM   = TERMS * LIT;
  localparam int SEC_BITS   = SEC_TERM + 2;
  localparam int TOTAL_BITS = NUM_SEC * SEC_BITS;

  cfgStrobe_t              strobe;
  logic [TOTAL_BITS-1:0]   activeMap;
  logic [NUM_SEC*SEC_TERM-1:0] termFuse;
  logic [NUM_SEC-1:0]      invBit;
  logic [NUM_SEC-1:0]      oeBit;
  logic [NUM_SEC-1:0]      orSum;

  pal_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgShift (cfgShift),
    .cfgCommit(cfgCommit),
    .strobe   (strobe)
  );

  pal_fuse_store #(.TOTAL_BITS(TOTAL_BITS)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .cfgData  (cfgData),
    .strobe   (strobe),
    .activeMap(activeMap)
  );

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    assign termFuse[s*SEC_TERM +: SEC_TERM] = activeMap[s*SEC_BITS +: SEC_TERM];
    assign invBit[s] = activeMap[s*SEC_BITS + SEC_TERM];
    assign oeBit[s]  = activeMap[s*SEC_BITS + SEC_TERM + 1];
    assign pinOut[s] = oeBit[s] ? (orSum[s] ^ invBit[s]) : 1'bz;
  end

  pal_and_or_plane #(.NUM_IN(NUM_IN), .NUM_SEC(NUM_SEC), .TERMS(TERMS)) u_plane (
    .termFuse(termFuse),
    .dataIn  (dataIn),
    .orSum   (orSum)
  );

endmodule

// File: tb/tb_pal_core.sv
`timescale 1ns/1ps
module tb_pal_core;

  localparam int SECB  = 50;
  localparam int TOTAL = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgData = 1'b0;
  logic       cfgShift = 1'b0;
  logic       cfgCommit = 1'b0;
  logic [3:0] dataIn = 4'h0;
  wire  [3:0] pinOut;

  int checks = 0;
  int fails  = 0;

  logic [TOTAL-1:0] map;

  always #5 clk = ~clk;

  pal_core dut (
    .clk(clk), .rstN(rstN), .cfgData(cfgData), .cfgShift(cfgShift),
    .cfgCommit(cfgCommit), .dataIn(dataIn), .pinOut(pinOut)
  );

  function automatic int colIn(int k, int neg);  return 2*k + neg;     endfunction
  function automatic int colFb(int s, int neg);  return 2*(4+s) + neg; endfunction

  task automatic setLit(int s, int t, int c); map[s*SECB + t*16 + c] = 1'b1; endtask
  task automatic setInv(int s); map[s*SECB + 48] = 1'b1; endtask
  task automatic setOe(int s);  map[s*SECB + 49] = 1'b1; endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pinOut=%b expected=%b (dataIn=%b)", req, act, exp, dataIn);
    end
  endtask

  task automatic shiftMap();
    for (int i = 0; i < TOTAL; i++) begin
      @(negedge clk);
      cfgData  = map[i];
      cfgShift = 1'b1;
    end
    @(negedge clk);
    cfgShift = 1'b0;
  endtask

  task automatic commitPulse();
    @(negedge clk);
    cfgCommit = 1'b1;
    @(negedge clk);
    cfgCommit = 1'b0;
  endtask

  task automatic applyIn(logic [3:0] v);
    dataIn = v;
    #1;
  endtask

  task automatic testReset();
    #1;
    chk("R1 during reset", pinOut, 4'bzzzz);
    @(negedge clk); rstN = 1'b1;
    applyIn(4'hF);
    chk("R1 after reset", pinOut, 4'bzzzz);
    commitPulse(); #1;
    chk("R1 commit of cleared chain", pinOut, 4'bzzzz);
  endtask

  task automatic testAndOr();
    logic f;
    map = '0;
    setLit(0, 0, colIn(0, 0)); setLit(0, 0, colIn(1, 1));
    setLit(0, 1, colIn(2, 0)); setLit(0, 1, colIn(3, 0));
    setOe(0); setOe(1);
    shiftMap(); commitPulse();
    for (int v = 0; v < 16; v++) begin
      applyIn(v[3:0]);
      f = (dataIn[0] & ~dataIn[1]) | (dataIn[2] & dataIn[3]);
      chk("R4 R5 R6 R10 sum of products", pinOut, {2'bzz, 1'b0, f});
    end
  endtask

  task automatic testInvert();
    map = '0;
    setLit(2, 0, colIn(0, 0)); setInv(2); setOe(2);
    setLit(3, 0, colFb(2, 0)); setOe(3);
    shiftMap(); commitPulse();
    for (int v = 0; v < 2; v++) begin
      applyIn({3'b101, v[0]});
      chk("R8 inverted pin, uninverted feedback", pinOut, {v[0], ~v[0], 2'bzz});
    end
  endtask

  task automatic loadChained();
    map = '0;
    setLit(0, 0, colIn(0, 0)); setLit(0, 0, colIn(1, 0));
    setLit(0, 1, colIn(2, 0)); setLit(0, 1, colIn(3, 0));
    setLit(0, 2, colIn(0, 1)); setLit(0, 2, colIn(3, 1));
    setLit(1, 0, colFb(0, 0));
    setLit(1, 1, colIn(1, 0)); setLit(1, 1, colIn(2, 1));
    setOe(1);
  endtask

  function automatic logic chainedF(logic [3:0] a);
    return (a[0] & a[1]) | (a[2] & a[3]) | (~a[0] & ~a[3]) | (a[1] & ~a[2]);
  endfunction

  task automatic testChain();
    loadChained();
    shiftMap(); commitPulse();
    for (int v = 0; v < 16; v++) begin
      applyIn(v[3:0]);
      chk("R7 R9 four-term function over two sections", pinOut,
          {2'bzz, chainedF(v[3:0]), 1'bz});
    end
  endtask

  task automatic testCommitRules();
    // chain still holds the two-section map; shift zeros without commit
    map = '0;
    shiftMap();
    applyIn(4'b0110);
    chk("R3 shift without commit keeps outputs", pinOut, {2'bzz, chainedF(4'b0110), 1'bz});
    applyIn(4'b0100);
    chk("R3 shift without commit keeps outputs", pinOut, {2'bzz, chainedF(4'b0100), 1'bz});
    // hold commit high: first edge commits the zero map
    @(negedge clk); cfgCommit = 1'b1;
    @(negedge clk); #1;
    chk("R3 commit on rising request", pinOut, 4'bzzzz);
    // shift a new map while commit stays high: no second commit
    map = '0;
    setLit(0, 0, colIn(0, 0)); setOe(0);
    shiftMap();
    repeat (3) @(negedge clk);
    applyIn(4'b0001);
    chk("R3 held commit does not recommit", pinOut, 4'bzzzz);
    cfgCommit = 1'b0;
    commitPulse(); #1;
    chk("R3 fresh commit request", pinOut, 4'bzzz1);
    applyIn(4'b0000);
    chk("R3 fresh commit request", pinOut, 4'bzzz0);
  endtask

  task automatic testDeepChain();
    map = '0;
    setLit(3, 0, colIn(0, 0)); setOe(3);
    setLit(2, 0, colFb(3, 0)); setOe(2);
    setLit(1, 0, colFb(2, 0)); setOe(1);
    setLit(0, 0, colFb(1, 0)); setOe(0);
    shiftMap(); commitPulse();
    for (int v = 0; v < 2; v++) begin
      applyIn({3'b000, v[0]});
      chk("R7 four-deep chain, descending order", pinOut, {4{v[0]}});
    end
    map = '0;
    setLit(0, 0, colIn(1, 1)); setOe(0);
    setLit(1, 0, colFb(0, 0)); setOe(1);
    setLit(2, 0, colFb(1, 0)); setOe(2);
    setLit(3, 0, colFb(2, 0)); setOe(3); setInv(3);
    shiftMap(); commitPulse();
    for (int v = 0; v < 2; v++) begin
      applyIn({2'b00, v[0], 1'b0});
      chk("R7 R8 four-deep chain, ascending order", pinOut,
          {v[0], ~v[0], ~v[0], ~v[0]});
    end
  endtask

  task automatic testContradiction();
    map = '0;
    setLit(0, 0, colIn(0, 0)); setLit(0, 0, colIn(0, 1));
    setLit(0, 1, colIn(3, 0));
    setLit(2, 2, colIn(1, 0));
    setOe(0); setOe(1);
    shiftMap(); commitPulse();
    for (int v = 0; v < 16; v++) begin
      applyIn(v[3:0]);
      chk("R5 R6 contradictory term and unshared terms", pinOut,
          {2'bzz, 1'b0, v[3]});
    end
  endtask

  task automatic testMidReset();
    @(negedge clk); rstN = 1'b0; #1;
    chk("R1 reset while configured", pinOut, 4'bzzzz);
    @(negedge clk); rstN = 1'b1;
    commitPulse(); #1;
    chk("R1 chain cleared by reset", pinOut, 4'bzzzz);
  endtask

  initial begin
    testReset();
    testAndOr();
    testInvert();
    testChain();
    testCommitRules();
    testDeepChain();
    testContradiction();
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(1_500_000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule